// File: doc/BRIEF.md
# SPI-Triggered Window Watchdog

This block watches a microcontroller through a window watchdog. After the main supply rail is good, it holds a reset request for a selectable delay. It then alternates between a closed window, where a trigger is forbidden, and an open window, where a trigger is expected. The trigger arrives as a one-cycle pulse taken from one bit of each serial control frame. A three-bit field of the same frame turns the supervision on or off. Time is counted in ticks of a millisecond strobe.

A trigger inside the open window restarts the closed window. A trigger in the closed window is a fault, and so is an open window that runs out without a trigger. On a fault the active-low error flag drops at once. The reset request follows after half a window length and is then held for the reset delay. After that a new closed window starts. The error flag stays low until the diagnosis path clears it.

Disabling the watchdog freezes its window timing. If the disable lasts longer than 1/48 of the window length, the timing is cleared, so the next enable starts with a full closed window.

Top module: `win_watchdog`

## Requirements
- R1: While `rst` is high, and after it falls with `rail_ok` low, `rst_req` is 1, `err_n` is 1 and `win_closed` is 1.
- R2: Once `rail_ok` is high, `rst_req` falls after D ticks, and a closed window begins. `dly_code` sets D in units of BASE_DLY_TICKS/8: code 00 gives 64, 10 gives 32, 01 gives 16 and 11 gives 8 (bit 1 is the left digit).
- R3: The closed window and the open window last W ticks each. `win_code` sets W in units of BASE_WIN_TICKS/16: code 00 gives 128, 10 gives 64, 01 gives 32 and 11 gives 16. `win_closed` reads 1 in the closed window and 0 in the open window.
- R4: A `trig` pulse in the open window starts a new full closed window and leaves `err_n` and `rst_req` unchanged.
- R5: A `trig` pulse in the closed window drives `err_n` low on the next clock edge.
- R6: If the open window ends without a trigger, `err_n` goes low on the tick that ends it.
- R7: After a fault, `rst_req` rises H = W/2 ticks later and falls D ticks after that. A closed window then starts.
- R8: Supervision runs only while `ctl_bits` equals 3'b010. Under any other value, the window timing is frozen and `trig` has no effect on `err_n` or on the window state.
- R9: A disable that lasts W/48 ticks or fewer (integer division) resumes the window where it stopped. A disable of more than W/48 ticks returns the window to the start of a full closed window.
- R10: Once low, `err_n` stays low until a cycle with `err_clr` high, which sets it back to 1.
- R11: `rail_ok` low drives `rst_req` to 1 on the next edge and restarts the reset delay.
- R12: All timing advances only on cycles with `ms_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle time-base strobe, nominally 1 ms |
| rail_ok | input | 1 | Main rail above its reset threshold |
| ctl_bits | input | 3 | Enable field taken from the control frame; 3'b010 enables |
| trig | input | 1 | One-cycle watchdog trigger pulse |
| err_clr | input | 1 | Clears the latched error |
| win_code | input | 2 | Window length select |
| dly_code | input | 2 | Reset delay select |
| err_n | output | 1 | Latched error flag, active low |
| rst_req | output | 1 | Reset request, active high |
| win_closed | output | 1 | 1 in the closed window, 0 in the open window |

## Verification
The bench builds the block with BASE_WIN_TICKS = 48 and BASE_DLY_TICKS = 8, and drives `ms_tick` high on every cycle except in the tick-gating test. This makes each tick one clock. The windows become 48, 96, 192 and 384 cycles, and the disable threshold becomes 1, 2, 4 and 8 ticks, so it is never zero. With these values, all sixteen combinations of window code and delay code can be swept, with exact cycle counts for release, closed window, open window, error and reset. The short-gap and long-gap disable cases use every non-enabling control code.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  typedef enum logic [1:0] {
    PH_DLY    = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_FAULT  = 2'd3
  } phase_t;

  // Code to left-shift of the base length: 00->3, 10->2, 01->1, 11->0.
  function automatic logic [1:0] code_shift(input logic [1:0] code);
    return ~{code[0], code[1]};
  endfunction

  function automatic int unsigned scaled_len(input int unsigned base, input logic [1:0] code);
    return base << code_shift(code);
  endfunction

endpackage

// File: rtl/wdg_timebase.sv
`timescale 1ns/1ps
module wdg_timebase #(
  parameter int unsigned BASE_WIN_TICKS = 16,
  parameter int unsigned BASE_DLY_TICKS = 8,
  parameter int unsigned LEN_W          = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       win_code,
  input  logic [1:0]       dly_code,
  output logic [LEN_W-1:0] win_len,
  output logic [LEN_W-1:0] half_len,
  output logic [LEN_W-1:0] dly_len,
  output logic [LEN_W-1:0] gap_thr
);
  import wdg_pkg::*;

  localparam int unsigned GAP_DIV = 48;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_len  <= LEN_W'(scaled_len(BASE_WIN_TICKS, 2'b00));
      half_len <= LEN_W'(scaled_len(BASE_WIN_TICKS, 2'b00) / 2);
      dly_len  <= LEN_W'(scaled_len(BASE_DLY_TICKS, 2'b00));
      gap_thr  <= LEN_W'(scaled_len(BASE_WIN_TICKS, 2'b00) / GAP_DIV);
    end else begin
      win_len  <= LEN_W'(scaled_len(BASE_WIN_TICKS, win_code));
      half_len <= LEN_W'(scaled_len(BASE_WIN_TICKS, win_code) / 2);
      dly_len  <= LEN_W'(scaled_len(BASE_DLY_TICKS, dly_code));
      gap_thr  <= LEN_W'(scaled_len(BASE_WIN_TICKS, win_code) / GAP_DIV);
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (win_len != '0) && (half_len != '0) && (dly_len != '0)); // R3

endmodule

// File: rtl/wdg_enable_gap.sv
`timescale 1ns/1ps
module wdg_enable_gap #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ctl_bits,
  input  logic             ms_tick,
  input  logic [LEN_W-1:0] gap_thr,
  output logic             wd_on,
  output logic             gap_clear
);
  localparam logic [2:0] RUN_CODE = 3'b010;

  logic [LEN_W-1:0] gap_cnt;
  logic             gap_done;

  assign wd_on     = (ctl_bits == RUN_CODE);
  assign gap_clear = !wd_on && ms_tick && !gap_done && (gap_cnt == gap_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      gap_done <= 1'b0;
    end else if (wd_on) begin
      gap_cnt  <= '0;
      gap_done <= 1'b0;
    end else if (ms_tick && !gap_done) begin
      if (gap_cnt == gap_thr) gap_done <= 1'b1;
      else                    gap_cnt  <= gap_cnt + LEN_W'(1);
    end
  end

  AST_GAP_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    gap_clear |=> !gap_clear); // R9

  AST_GAP_NEEDS_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_done) |-> $past(!wd_on)); // R9

endmodule

// File: rtl/wdg_window_fsm.sv
`timescale 1ns/1ps
module wdg_window_fsm #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             rail_ok,
  input  logic             wd_on,
  input  logic             gap_clear,
  input  logic             trig,
  input  logic             err_clr,
  input  logic [LEN_W-1:0] win_len,
  input  logic [LEN_W-1:0] half_len,
  input  logic [LEN_W-1:0] dly_len,
  output logic             err_n,
  output logic             rst_req,
  output logic             win_closed
);
  import wdg_pkg::*;

  phase_t           phase;
  logic [LEN_W-1:0] cnt;
  logic             err_lat;
  logic [LEN_W-1:0] win_last;
  logic [LEN_W-1:0] half_last;
  logic [LEN_W-1:0] dly_last;

  assign win_last  = win_len  - LEN_W'(1);
  assign half_last = half_len - LEN_W'(1);
  assign dly_last  = dly_len  - LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_DLY;
      cnt     <= '0;
      rst_req <= 1'b1;
      err_lat <= 1'b0;
    end else begin
      if (err_clr) err_lat <= 1'b0;
      if (!rail_ok) begin
        phase   <= PH_DLY;
        cnt     <= '0;
        rst_req <= 1'b1;
      end else begin
        unique case (phase)
          PH_DLY: begin
            rst_req <= 1'b1;
            if (ms_tick) begin
              if (cnt >= dly_last) begin
                phase   <= PH_CLOSED;
                cnt     <= '0;
                rst_req <= 1'b0;
              end else begin
                cnt <= cnt + LEN_W'(1);
              end
            end
          end
          PH_CLOSED: begin
            if (gap_clear) begin
              cnt <= '0;
            end else if (wd_on) begin
              if (trig) begin
                err_lat <= 1'b1;
                phase   <= PH_FAULT;
                cnt     <= '0;
              end else if (ms_tick) begin
                if (cnt >= win_last) begin
                  phase <= PH_OPEN;
                  cnt   <= '0;
                end else begin
                  cnt <= cnt + LEN_W'(1);
                end
              end
            end
          end
          PH_OPEN: begin
            if (gap_clear) begin
              phase <= PH_CLOSED;
              cnt   <= '0;
            end else if (wd_on) begin
              if (trig) begin
                phase <= PH_CLOSED;
                cnt   <= '0;
              end else if (ms_tick) begin
                if (cnt >= win_last) begin
                  err_lat <= 1'b1;
                  phase   <= PH_FAULT;
                  cnt     <= '0;
                end else begin
                  cnt <= cnt + LEN_W'(1);
                end
              end
            end
          end
          PH_FAULT: begin
            if (ms_tick) begin
              if (cnt >= half_last) begin
                phase   <= PH_DLY;
                cnt     <= '0;
                rst_req <= 1'b1;
              end else begin
                cnt <= cnt + LEN_W'(1);
              end
            end
          end
          default: begin
            phase <= PH_DLY;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  assign err_n      = !err_lat;
  assign win_closed = (phase != PH_OPEN);

  AST_RAIL_DROP_RESET: assert property (@(posedge clk) disable iff (rst)
    !rail_ok |=> rst_req); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_lat && !err_clr) |=> err_lat); // R10

  AST_ERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_lat) |-> $past(wd_on)); // R8

  AST_OPEN_FROM_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $fell(win_closed) |-> ($past(phase) == PH_CLOSED)); // R3

  AST_RST_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> (($past(phase) == PH_FAULT) || !$past(rail_ok))); // R7

  AST_RELEASE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> (phase == PH_CLOSED)); // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ms_tick && !trig && !gap_clear && rail_ok) |=> $stable(cnt)); // R12

endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog #(
  parameter int unsigned BASE_WIN_TICKS = 16,
  parameter int unsigned BASE_DLY_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       rail_ok,
  input  logic [2:0] ctl_bits,
  input  logic       trig,
  input  logic       err_clr,
  input  logic [1:0] win_code,
  input  logic [1:0] dly_code,
  output logic       err_n,
  output logic       rst_req,
  output logic       win_closed
);
  localparam int unsigned MAX_BASE = (BASE_WIN_TICKS > BASE_DLY_TICKS) ? BASE_WIN_TICKS : BASE_DLY_TICKS;
  localparam int unsigned MAX_LEN  = MAX_BASE * 8;
  localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] win_len;
  logic [LEN_W-1:0] half_len;
  logic [LEN_W-1:0] dly_len;
  logic [LEN_W-1:0] gap_thr;
  logic             wd_on;
  logic             gap_clear;

  wdg_timebase #(
    .BASE_WIN_TICKS(BASE_WIN_TICKS),
    .BASE_DLY_TICKS(BASE_DLY_TICKS),
    .LEN_W         (LEN_W)
  ) timebase_i (
    .clk     (clk),
    .rst     (rst),
    .win_code(win_code),
    .dly_code(dly_code),
    .win_len (win_len),
    .half_len(half_len),
    .dly_len (dly_len),
    .gap_thr (gap_thr)
  );

  wdg_enable_gap #(
    .LEN_W(LEN_W)
  ) enable_i (
    .clk      (clk),
    .rst      (rst),
    .ctl_bits (ctl_bits),
    .ms_tick  (ms_tick),
    .gap_thr  (gap_thr),
    .wd_on    (wd_on),
    .gap_clear(gap_clear)
  );

  wdg_window_fsm #(
    .LEN_W(LEN_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .ms_tick   (ms_tick),
    .rail_ok   (rail_ok),
    .wd_on     (wd_on),
    .gap_clear (gap_clear),
    .trig      (trig),
    .err_clr   (err_clr),
    .win_len   (win_len),
    .half_len  (half_len),
    .dly_len   (dly_len),
    .err_n     (err_n),
    .rst_req   (rst_req),
    .win_closed(win_closed)
  );

endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;

  localparam int unsigned BW = 48;
  localparam int unsigned BD = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       ms_tick;
  logic       rail_ok;
  logic [2:0] ctl_bits;
  logic       trig;
  logic       err_clr;
  logic [1:0] win_code;
  logic [1:0] dly_code;
  logic       err_n;
  logic       rst_req;
  logic       win_closed;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  win_watchdog #(.BASE_WIN_TICKS(BW), .BASE_DLY_TICKS(BD)) dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .rail_ok(rail_ok),
    .ctl_bits(ctl_bits), .trig(trig), .err_clr(err_clr),
    .win_code(win_code), .dly_code(dly_code),
    .err_n(err_n), .rst_req(rst_req), .win_closed(win_closed)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0:       return err_n;
      1:       return rst_req;
      default: return win_closed;
    endcase
  endfunction

  task automatic wait_for(input int sel, input logic lvl, output int n);
    n = 0;
    do begin
      edge1();
      n++;
    end while (pick(sel) != lvl && n < 5000);
  endtask

  function automatic int win_ticks(input logic [1:0] c);
    case (c)
      2'b00:   return 128 * BW / 16;
      2'b10:   return 64 * BW / 16;
      2'b01:   return 32 * BW / 16;
      default: return 16 * BW / 16;
    endcase
  endfunction

  function automatic int dly_ticks(input logic [1:0] c);
    case (c)
      2'b00:   return 64 * BD / 8;
      2'b10:   return 32 * BD / 8;
      2'b01:   return 16 * BD / 8;
      default: return 8 * BD / 8;
    endcase
  endfunction

  function automatic logic [2:0] off_code(input int k);
    int v = k % 7;
    if (v >= 2) v++;
    return 3'(v);
  endfunction

  task automatic pulse_trig();
    trig = 1'b1;
    edge1();
    trig = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int n;
    int W;
    int D;
    rst = 1'b1; ms_tick = 1'b1; rail_ok = 1'b0; ctl_bits = 3'b010;
    trig = 1'b0; err_clr = 1'b0; win_code = 2'b00; dly_code = 2'b00;
    repeat (4) edge1();
    check("R1 rst_req in reset", int'(rst_req), 1);
    check("R1 err_n in reset", int'(err_n), 1);
    check("R1 win_closed in reset", int'(win_closed), 1);
    rst = 1'b0;
    repeat (3) edge1();
    check("R1 rst_req held rail low", int'(rst_req), 1);
    check("R1 err_n after reset", int'(err_n), 1);

    for (int idx = 0; idx < 16; idx++) begin
      rail_ok = 1'b0;
      edge1();
      check("R11 rail drop asserts reset", int'(rst_req), 1);
      win_code = 2'(idx / 4);
      dly_code = 2'(idx % 4);
      ctl_bits = 3'b010;
      W = win_ticks(win_code);
      D = dly_ticks(dly_code);
      err_clr = 1'b1;
      edge1();
      err_clr = 1'b0;
      edge1(); edge1();
      check("R10 err_clr restores err_n", int'(err_n), 1);
      rail_ok = 1'b1;
      wait_for(1, 1'b0, n);
      check("R2 reset delay", n, D);
      check("R2 closed after release", int'(win_closed), 1);
      wait_for(2, 1'b0, n);
      check("R3 closed window length", n, W);

      if (idx % 3 == 0) begin
        wait_for(0, 1'b0, n);
        check("R6 missing trigger error", n, W);
        wait_for(1, 1'b1, n);
        check("R7 reset after half window", n, W / 2);
        wait_for(1, 1'b0, n);
        check("R7 reset held for delay", n, D);
        check("R7 closed window after reset", int'(win_closed), 1);
        check("R10 error still latched", int'(err_n), 0);
      end else if (idx % 3 == 1) begin
        repeat (W / 2) edge1();
        pulse_trig();
        check("R4 valid trigger no error", int'(err_n), 1);
        check("R4 valid trigger no reset", int'(rst_req), 0);
        check("R4 closed after trigger", int'(win_closed), 1);
        wait_for(2, 1'b0, n);
        check("R4 full closed after trigger", n, W);
        pulse_trig();
        repeat (3) edge1();
        pulse_trig();
        check("R5 early trigger error", int'(err_n), 0);
        wait_for(1, 1'b1, n);
        check("R7 reset after early trigger", n, W / 2);
      end else begin
        pulse_trig();
        repeat (5) edge1();
        ctl_bits = off_code(idx);
        pulse_trig();
        repeat (W / 48 - 1) edge1();
        check("R8 trigger ignored when off", int'(err_n), 1);
        check("R8 window frozen when off", int'(win_closed), 1);
        ctl_bits = 3'b010;
        wait_for(2, 1'b0, n);
        check("R9 short gap resumes", n, W - 5);
        ctl_bits = off_code(idx + 3);
        repeat (W + 10) edge1();
        check("R8 no missing-trigger error when off", int'(err_n), 1);
        check("R9 long gap returns to closed", int'(win_closed), 1);
        ctl_bits = 3'b010;
        wait_for(2, 1'b0, n);
        check("R9 full closed after long gap", n, W);
      end
    end

    rail_ok = 1'b0;
    win_code = 2'b11; dly_code = 2'b11; ctl_bits = 3'b010;
    err_clr = 1'b1;
    repeat (3) edge1();
    err_clr = 1'b0;
    ms_tick = 1'b0;
    rail_ok = 1'b1;
    repeat (20) edge1();
    check("R12 delay frozen without tick", int'(rst_req), 1);
    ms_tick = 1'b1;
    wait_for(1, 1'b0, n);
    check("R12 delay after tick resumes", n, dly_ticks(2'b11));
    ms_tick = 1'b0;
    repeat (30) edge1();
    check("R12 closed frozen without tick", int'(win_closed), 1);
    ms_tick = 1'b1;
    wait_for(2, 1'b0, n);
    check("R12 closed length after tick resumes", n, win_ticks(2'b11));

    summary();
    $finish;
  end

endmodule